// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This unit holds four alarm bytes in BCD: seconds, minutes, hours and day-of-month. On each one-second strobe it compares them against the time supplied by an external calendar counter. When the comparison succeeds it raises a one-cycle interrupt pulse.

Bit 7 of every alarm byte is a repeat flag. The four flags are decoded together into a repeat pattern. That pattern decides which time fields take part in the comparison, so the alarm fires once a month, once a day, once an hour, once a minute, or on every second. Software loads the alarm bytes through a byte-wide write port and can read any of them back through a combinational read port. A write whose value is out of range for its field is discarded.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, all four alarm bytes read 0x00 and `irq` is low. No pulse is produced, even on a matching tick, until at least one write has been accepted.
- R2: Field select codes are 0 for seconds, 1 for minutes, 2 for hours and 3 for date. A write to seconds or minutes is stored whole only when its low 7 bits form two decimal digits (each nibble at most 9) with value 0 to 59. Otherwise the stored byte is left unchanged.
- R3: A write to hours is stored whole only when its low 6 bits form valid BCD digits with value 0 to 23. Otherwise it is discarded.
- R4: A write to date is stored whole only when its low 6 bits form valid BCD digits with a nonzero value. Otherwise it is discarded.
- R5: Comparison uses bits 6:0 of seconds and minutes and bits 5:0 of hours and date. When all four repeat flags (bit 7) are clear, a pulse needs date, hour, minute and second all to match.
- R6: When only the date repeat flag is set, a pulse needs hour, minute and second to match.
- R7: When only the date and hour repeat flags are set, a pulse needs minute and second to match.
- R8: When the date, hour and minute flags are set and the seconds flag is clear, a pulse needs only the second to match.
- R9: Any other flag pattern, including all four set, gives a pulse on every tick.
- R10: Matching is evaluated only in a cycle with `tick` high. The pulse appears on `irq` in the following cycle and lasts one cycle. With `tick` low, `irq` stays low.
- R11: `rd_data` combinationally shows the whole stored byte of the field chosen by `rd_sel`, repeat flag included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one alarm byte |
| wr_sel | input | 2 | Field written (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Byte written, bit 7 is the repeat flag |
| rd_sel | input | 2 | Field shown on rd_data |
| rd_data | output | 8 | Stored alarm byte of the selected field |
| tick | input | 1 | One-second strobe, one cycle wide |
| now_sec | input | 8 | Current seconds in BCD |
| now_min | input | 8 | Current minutes in BCD |
| now_hour | input | 8 | Current hours in BCD |
| now_date | input | 8 | Current day of month in BCD |
| irq | output | 1 | Alarm pulse |

## Verification
On every cycle the assertions check four things. A rejected write leaves all alarm bytes untouched, and an accepted write lands in its field. No pulse appears without a preceding tick or before arming. The every-second pattern always reports a hit. Whether each repeat pattern compares exactly the right fields, and whether each value is accepted or refused at the range limits, only the bench's scenarios can show. The bench writes every one of the 256 byte values to every field. It then walks a grid of times under seven flag patterns and predicts each pulse from its own field-count model.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FIELD_CNT   = 4;
  localparam int BYTE_W      = 8;
  localparam int FIELD_SEL_W = $clog2(FIELD_CNT);
  localparam int BIN_W       = 7;

  typedef enum logic [FIELD_SEL_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } field_e;

  typedef enum logic [2:0] {
    RPT_MONTH = 3'd0,
    RPT_DAY   = 3'd1,
    RPT_HOUR  = 3'd2,
    RPT_MIN   = 3'd3,
    RPT_SEC   = 3'd4
  } repeat_e;

  // Significant bits of each field; bit 7 is always the repeat flag.
  function automatic logic [BYTE_W-1:0] field_mask(field_e f);
    case (f)
      FLD_SEC, FLD_MIN: return 8'h7F;
      default:          return 8'h3F;
    endcase
  endfunction

  function automatic logic digit_ok(logic [3:0] d);
    return d <= 4'd9;
  endfunction

  function automatic logic [BIN_W-1:0] bcd_value(logic [BYTE_W-1:0] b);
    return BIN_W'(b[7:4]) * BIN_W'(10) + BIN_W'(b[3:0]);
  endfunction

  // Range rule of each field, applied to the masked value.
  function automatic logic write_ok(field_e f, logic [BYTE_W-1:0] raw);
    logic [BYTE_W-1:0] m;
    logic [BIN_W-1:0]  v;
    logic              ok;
    m  = raw & field_mask(f);
    v  = bcd_value(m);
    ok = digit_ok(m[7:4]) && digit_ok(m[3:0]);
    case (f)
      FLD_SEC, FLD_MIN: ok = ok && (v <= BIN_W'(59));
      FLD_HOUR:         ok = ok && (v <= BIN_W'(23));
      default:          ok = ok && (v != '0);
    endcase
    return ok;
  endfunction

  // Flags ordered {date, hour, min, sec}.
  function automatic repeat_e decode_repeat(logic [FIELD_CNT-1:0] r);
    case (r)
      4'b0000: return RPT_MONTH;
      4'b1000: return RPT_DAY;
      4'b1100: return RPT_HOUR;
      4'b1110: return RPT_MIN;
      default: return RPT_SEC;
    endcase
  endfunction

  // Which fields (bit 0 = sec .. bit 3 = date) must be equal for a hit.
  function automatic logic [FIELD_CNT-1:0] compare_set(repeat_e m);
    case (m)
      RPT_MONTH: return 4'b1111;
      RPT_DAY:   return 4'b0111;
      RPT_HOUR:  return 4'b0011;
      RPT_MIN:   return 4'b0001;
      default:   return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [FIELD_SEL_W-1:0]             wr_sel,
  input  logic [BYTE_W-1:0]                  wr_data,
  input  logic [FIELD_SEL_W-1:0]             rd_sel,
  output logic [BYTE_W-1:0]                  rd_data,
  output logic [FIELD_CNT-1:0][BYTE_W-1:0]   alarm_q,
  output logic                               armed
);
  logic [BYTE_W-1:0] store_q [FIELD_CNT];
  logic              wr_ok;
  logic              armed_q;
  field_e            wr_field;

  assign wr_field = field_e'(wr_sel);
  assign wr_ok    = wr_en && write_ok(wr_field, wr_data);

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_fld
    localparam logic [FIELD_SEL_W-1:0] IDX = FIELD_SEL_W'(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      store_q[g] <= '0;
      else if (wr_ok && wr_sel == IDX) store_q[g] <= wr_data;
    end

    assign alarm_q[g] = store_q[g];

    AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_sel == IDX) |=> (alarm_q[g] == $past(wr_data))); // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_ok) armed_q <= 1'b1;
  end

  assign armed   = armed_q;
  assign rd_data = store_q[rd_sel];

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> $stable(alarm_q)); // R2

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed); // R1
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [FIELD_CNT-1:0][BYTE_W-1:0] alarm_q,
  input  logic [FIELD_CNT-1:0][BYTE_W-1:0] now_q,
  output logic                             hit
);
  logic [FIELD_CNT-1:0] field_eq;
  logic [FIELD_CNT-1:0] rpt_flags;
  logic [FIELD_CNT-1:0] need;
  repeat_e              mode;

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_cmp
    localparam field_e FLD = field_e'(FIELD_SEL_W'(g));
    assign field_eq[g]  = ((alarm_q[g] ^ now_q[g]) & field_mask(FLD)) == '0;
    assign rpt_flags[g] = alarm_q[g][BYTE_W-1];
  end

  assign mode = decode_repeat(rpt_flags);
  assign need = compare_set(mode);
  assign hit  = &(field_eq | ~need);

  AST_SECOND_MODE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RPT_SEC) |-> hit); // R9

  AST_MONTH_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RPT_MONTH && hit) |-> (&field_eq)); // R5
endmodule

// File: rtl/rtc_alarm_pulse.sv
module rtc_alarm_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic hit,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= tick && armed && hit;
  end

  assign irq = irq_q;

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq); // R10

  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !irq); // R1
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [FIELD_SEL_W-1:0] wr_sel,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [FIELD_SEL_W-1:0] rd_sel,
  output logic [BYTE_W-1:0]      rd_data,
  input  logic                   tick,
  input  logic [BYTE_W-1:0]      now_sec,
  input  logic [BYTE_W-1:0]      now_min,
  input  logic [BYTE_W-1:0]      now_hour,
  input  logic [BYTE_W-1:0]      now_date,
  output logic                   irq
);
  logic [FIELD_CNT-1:0][BYTE_W-1:0] alarm_q;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] now_q;
  logic                             armed;
  logic                             hit;

  assign now_q = {now_date, now_hour, now_min, now_sec};

  rtc_alarm_regs regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .alarm_q (alarm_q),
    .armed   (armed)
  );

  rtc_alarm_match match_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .alarm_q (alarm_q),
    .now_q   (now_q),
    .hit     (hit)
  );

  rtc_alarm_pulse pulse_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .armed (armed),
    .hit   (hit),
    .irq   (irq)
  );
endmodule

// File: tb/rtc_alarm_unit_tb_top.sv
module rtc_alarm_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
  logic       irq;

  int checks = 0;
  int failures = 0;
  int shadow [4];

  always #10 clk = ~clk;

  rtc_alarm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick), .now_sec(now_sec),
    .now_min(now_min), .now_hour(now_hour), .now_date(now_date), .irq(irq)
  );

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int to_bcd(input int x);
    return ((x / 10) * 16) + (x % 10);
  endfunction

  function automatic bit tb_accept(input int sel, input int raw);
    int m, tens, ones, v;
    m = (sel < 2) ? (raw % 128) : (raw % 64);
    tens = m / 16;
    ones = m % 16;
    if (tens > 9 || ones > 9) return 1'b0;
    v = tens * 10 + ones;
    if (sel < 2)  return v <= 59;
    if (sel == 2) return v <= 23;
    return v != 0;
  endfunction

  task automatic write_reg(input int sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
    if (tb_accept(sel, val)) shadow[sel] = val;
  endtask

  task automatic tick_at(input int s, input int m, input int h, input int d,
                         input bit exp, input string tag);
    @(negedge clk);
    now_sec = 8'(to_bcd(s) + ((s % 2) * 128));
    now_min = 8'(to_bcd(m)); now_hour = 8'(to_bcd(h)); now_date = 8'(to_bcd(d));
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    expect_eq(tag, int'(irq), int'(exp));
    if (exp) begin
      @(negedge clk);
      expect_eq({tag, " R10 width"}, int'(irq), 0);
    end
  endtask

  // flags ordered {date,hour,min,sec}; alarm 01 05:07:30
  task automatic run_pattern(input logic [3:0] f, input string tag);
    int ncmp;
    bit exp;
    write_reg(0, 8'h30 | (int'(f[0]) * 128));
    write_reg(1, 8'h07 | (int'(f[1]) * 128));
    write_reg(2, 8'h05 | (int'(f[2]) * 128));
    write_reg(3, 8'h01 | (int'(f[3]) * 128));
    case (f)
      4'b0000: ncmp = 4;
      4'b1000: ncmp = 3;
      4'b1100: ncmp = 2;
      4'b1110: ncmp = 1;
      default: ncmp = 0;
    endcase
    for (int d = 1; d <= 2; d++)
      for (int h = 5; h <= 6; h++)
        for (int k = 0; k < 3; k++)
          for (int s = 0; s < 60; s++) begin
            int m;
            m = (k == 0) ? 7 : ((k == 1) ? 8 : 30);
            exp = (ncmp < 1 || s == 30) && (ncmp < 2 || m == 7) &&
                  (ncmp < 3 || h == 5) && (ncmp < 4 || d == 1);
            tick_at(s, m, h, d, exp, tag);
          end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R11: reset contents and quiet output
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1 expect_eq("R1 R11 reset byte", int'(rd_data), 0);
    end
    expect_eq("R1 irq low", int'(irq), 0);
    // all-zero time matches all-zero alarm, but nothing is armed yet
    tick_at(0, 0, 0, 0, 1'b0, "R1 unarmed");
    tick_at(0, 0, 0, 0, 1'b0, "R1 unarmed");

    // Exhaustive value sweep per field: R2 R3 R4 R11
    for (int sel = 0; sel < 4; sel++) begin
      string tag;
      tag = (sel < 2) ? "R2 sec/min" : ((sel == 2) ? "R3 hour" : "R4 date");
      rd_sel = 2'(sel);
      for (int v = 0; v < 256; v++) begin
        write_reg(sel, v);
        #1 expect_eq(tag, int'(rd_data), shadow[sel]);
      end
    end

    // R10: matching time held with no tick gives no pulse
    write_reg(0, 8'hB0); write_reg(1, 8'h87); write_reg(2, 8'h85); write_reg(3, 8'h81);
    now_sec = 8'h30; now_min = 8'h07; now_hour = 8'h05; now_date = 8'h01;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      expect_eq("R10 no tick", int'(irq), 0);
    end

    run_pattern(4'b0000, "R5 monthly");
    run_pattern(4'b1000, "R6 daily");
    run_pattern(4'b1100, "R7 hourly");
    run_pattern(4'b1110, "R8 per-minute");
    run_pattern(4'b1111, "R9 every second");
    run_pattern(4'b0001, "R9 odd pattern");
    run_pattern(4'b0110, "R9 odd pattern");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule